// File: doc/BRIEF.md
# Power-Up Bring-Up Test Sequencer

This block walks a device under test through a fixed, scripted bring-up. It starts with every device pin floating and the test and reset lines held low. It then releases reset while a strap pin and the serial data pin are pulled high. Next it streams a boot image, one bit at a time, onto the data pin at a fixed bit period. Two reference square waves run while the image loads. After a set of long waits, it reads an 8-bit status field from the top device pins. It also counts the edges of the oscillator output that the device returns. From these two readings it reports pass or fail.

All intervals are parameters counted in system-clock cycles. A simulation can therefore shrink them while keeping their ratios. The boot image comes from a ready/valid source. A source that stalls pauses the bit timer and holds the pin level. Every pin sample passes through a two-flop synchronizer before it is used.

The state machine has eight states:
- `ST_IDLE`: nothing is driven. `start` leads to `ST_PRE`.
- `ST_PRE`: the test and reset lines are held low. After `PRE_CYC` cycles it goes to `ST_STRAP`.
- `ST_STRAP`: reset is released, and the strap and data pins are driven high. After `STRAP_CYC` cycles it goes to `ST_LOAD`.
- `ST_LOAD`: the image is streamed. When the period of the bit marked last expires it goes to `ST_DRAIN`.
- `ST_DRAIN`: the reference clock keeps running. After `POST_CYC` cycles it goes to `ST_SETTLE`.
- `ST_SETTLE`: the reference pin is floated. After `SETTLE_CYC` cycles it goes to `ST_GATE`.
- `ST_GATE`: oscillator edges are counted. After `GATE_CYC` cycles it goes to `ST_DONE`.
- `ST_DONE`: the verdict is shown. `start` leads back to `ST_PRE`.

Top module: `pwrup_seq`

## Requirements
- R1: In reset and in `ST_IDLE`, `done`, `pass`, `ctl_oe`, `xi_oe` and every bit of `pin_oe` are low. At no time does `pin_oe` enable any pin other than the strap pin (index 59), the data pin (index 63) or the reference pin (index 62).
- R2: One cycle after `start` is sampled, `ctl_oe` is high with `dut_test_o` and `dut_rst_o` low. No pin is driven, and this lasts exactly `PRE_CYC` cycles.
- R3: For the next `STRAP_CYC` cycles, `dut_rst_o` is high. The strap pin and the data pin are both enabled and driven to 1. After that the strap pin is released for the rest of the run.
- R4: While the load runs, an accepted bit (`bit_ready` and `bit_valid` high at a clock edge) appears on the data pin on the following cycle. It stays there for exactly `BIT_CYC` cycles. With a continuous source, the next bit follows with no gap.
- R5: If no valid bit is offered when a bit period ends, the data pin keeps its last level and `bit_ready` stays high until a bit is accepted. The load ends only after the full period of a bit accepted with `bit_last` high.
- R6: When the last bit's period ends, the data pin is released. It stays released until the next run.
- R7: From the first load cycle, the reference pin carries a square wave that starts low with half-period `REF_HALF`. `xi_o` carries one that starts low with half-period `XI_HALF`. `xi_oe` stays high through `ST_DRAIN`, `ST_SETTLE` and `ST_GATE`.
- R8: The reference pin is released `POST_CYC` cycles after the load ends. The edge-counting window of `GATE_CYC` cycles opens `SETTLE_CYC` cycles after that.
- R9: `pass` is high only in `ST_DONE`, and only if the captured status pins [63:56] equal 8'hC3 and the rising-edge count of `xo_in` over the window lies within `EXP_EDGES` ± `EXP_EDGES*TOL_PCT/100`.
- R10: The status pins and `xo_in` each pass through two flops before use. A status change that reaches the pins one cycle before the capture edge does not affect the verdict.
- R11: In `ST_DONE`, `done` is high, and `ctl_oe`, `xi_oe` and all of `pin_oe` are low. `done` holds until `start` begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (from idle or done) |
| done | output | 1 | Run complete |
| pass | output | 1 | Verdict, valid while `done` is high |
| bit_valid | input | 1 | Bit source offers a bit |
| bit_data | input | 1 | Offered bit value |
| bit_last | input | 1 | Offered bit is the final one |
| bit_ready | output | 1 | Sequencer accepts the offered bit |
| pin_o | output | NUM_PINS | Drive level per device pin |
| pin_oe | output | NUM_PINS | Output enable per device pin |
| pin_in | input | NUM_PINS | Sampled level per device pin |
| dut_test_o | output | 1 | Test-mode line level |
| dut_rst_o | output | 1 | Device reset line level (high = released) |
| ctl_oe | output | 1 | Enable for test and reset lines |
| xi_o | output | 1 | Crystal-input reference clock |
| xi_oe | output | 1 | Enable for `xi_o` |
| xo_in | input | 1 | Oscillator output returned by the device |

## Verification
The bound checker enforces, on every cycle, the properties that hold at every instant:
- pins stay inside the allowed set;
- the strap, data and reference pins are enabled only together with their companion lines;
- the data level stays stable between handshakes;
- `done` floats everything and holds until `start`;
- `pass` appears only with `done`.

Exact phase lengths, bit timing under a stalling source, square-wave phase, the edge count over the window and the synchronizer latency on the status capture can only be shown by the bench scenarios. The bench compares these against its cycle model under good, wrong-status, fast, slow and stuck oscillator cases.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_STRAP,
        ST_LOAD,
        ST_DRAIN,
        ST_SETTLE,
        ST_GATE,
        ST_DONE
    } seq_state_e;

    localparam logic [7:0] STATUS_GOOD = 8'hC3;

    function automatic logic count_in_window(input int unsigned cnt,
                                             input int unsigned centre,
                                             input int unsigned tol);
        return (cnt + tol >= centre) && (cnt <= centre + tol);
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= d_i[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/sq_toggler.sv
module sq_toggler #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic lvl_o
);
    localparam int CW = $clog2(HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (!en_i) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/bit_feeder.sv
module bit_feeder #(
    parameter int BIT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic valid_i,
    input  logic data_i,
    input  logic last_i,
    output logic ready_o,
    output logic level_o,
    output logic finished_o
);
    localparam int TW = $clog2(BIT_CYC + 1);
    localparam logic [TW-1:0] TEND = TW'(BIT_CYC - 1);

    logic [TW-1:0] tmr_q;
    logic          busy_q;
    logic          last_q;
    logic          lvl_q;
    logic          expire;

    assign expire     = busy_q && (tmr_q == TEND);
    assign ready_o    = run_i && (!busy_q || (expire && !last_q));
    assign finished_o = run_i && expire && last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            busy_q <= 1'b0;
            last_q <= 1'b0;
            lvl_q  <= 1'b1;
        end else if (!run_i) begin
            tmr_q  <= '0;
            busy_q <= 1'b0;
            last_q <= 1'b0;
            lvl_q  <= 1'b1;
        end else if (ready_o && valid_i) begin
            tmr_q  <= '0;
            busy_q <= 1'b1;
            last_q <= last_i;
            lvl_q  <= data_i;
        end else if (busy_q) begin
            if (expire) begin
                busy_q <= 1'b0;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign level_o = lvl_q;
endmodule

// File: rtl/edge_meter.sv
module edge_meter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          sig_i,
    output logic [CW-1:0] count_o
);
    logic          dly_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            dly_q <= sig_i;
            if (clr_i) begin
                cnt_q <= '0;
            end else if (en_i && sig_i && !dly_q && (cnt_q != '1)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int NUM_PINS   = 64,
    parameter int STRAP_IDX  = 59,
    parameter int DATA_IDX   = 63,
    parameter int REF_IDX    = 62,
    parameter int STAT_LSB   = 56,
    parameter int STAT_W     = 8,
    parameter int CNT_W      = 32,
    parameter int PRE_CYC    = 2000,
    parameter int STRAP_CYC  = 1200000,
    parameter int BIT_CYC    = 100,
    parameter int REF_HALF   = 100,
    parameter int XI_HALF    = 5,
    parameter int POST_CYC   = 1000000,
    parameter int SETTLE_CYC = 14000000,
    parameter int GATE_CYC   = 20000,
    parameter int EXP_EDGES  = 2000,
    parameter int TOL_PCT    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                done,
    output logic                pass,
    input  logic                bit_valid,
    input  logic                bit_data,
    input  logic                bit_last,
    output logic                bit_ready,
    output logic [NUM_PINS-1:0] pin_o,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                dut_test_o,
    output logic                dut_rst_o,
    output logic                ctl_oe,
    output logic                xi_o,
    output logic                xi_oe,
    input  logic                xo_in
);
    localparam int EDGE_W = $clog2(GATE_CYC + 1);
    localparam int TOL    = (EXP_EDGES * TOL_PCT) / 100;
    localparam logic [CNT_W-1:0] END_PRE    = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0] END_STRAP  = CNT_W'(STRAP_CYC - 1);
    localparam logic [CNT_W-1:0] END_POST   = CNT_W'(POST_CYC - 1);
    localparam logic [CNT_W-1:0] END_SETTLE = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] END_GATE   = CNT_W'(GATE_CYC - 1);

    seq_state_e state_q, state_d;
    logic [CNT_W-1:0]  phase_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_s;
    logic              xo_s;
    logic              load_done;
    logic              data_lvl;
    logic              ref_lvl;
    logic              xi_lvl;
    logic              ref_run;
    logic              xi_run;
    logic              load_run;
    logic [EDGE_W-1:0] edge_cnt;

    // Synchronizers for the status field and the returned oscillator
    pin_sync #(.W(STAT_W)) u_stat_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in[STAT_LSB +: STAT_W]),
        .q_o   (stat_s)
    );

    pin_sync #(.W(1)) u_xo_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (xo_in),
        .q_o   (xo_s)
    );

    assign load_run = (state_q == ST_LOAD);
    assign ref_run  = (state_q == ST_LOAD) || (state_q == ST_DRAIN);
    assign xi_run   = (state_q == ST_LOAD) || (state_q == ST_DRAIN) ||
                      (state_q == ST_SETTLE) || (state_q == ST_GATE);

    bit_feeder #(.BIT_CYC(BIT_CYC)) u_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (load_run),
        .valid_i    (bit_valid),
        .data_i     (bit_data),
        .last_i     (bit_last),
        .ready_o    (bit_ready),
        .level_o    (data_lvl),
        .finished_o (load_done)
    );

    sq_toggler #(.HALF(REF_HALF)) u_ref_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (ref_run),
        .lvl_o (ref_lvl)
    );

    sq_toggler #(.HALF(XI_HALF)) u_xi_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (xi_run),
        .lvl_o (xi_lvl)
    );

    edge_meter #(.CW(EDGE_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (state_q == ST_SETTLE),
        .en_i    (state_q == ST_GATE),
        .sig_i   (xo_s),
        .count_o (edge_cnt)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)                 state_d = ST_PRE;
            ST_PRE:    if (phase_q == END_PRE)    state_d = ST_STRAP;
            ST_STRAP:  if (phase_q == END_STRAP)  state_d = ST_LOAD;
            ST_LOAD:   if (load_done)             state_d = ST_DRAIN;
            ST_DRAIN:  if (phase_q == END_POST)   state_d = ST_SETTLE;
            ST_SETTLE: if (phase_q == END_SETTLE) state_d = ST_GATE;
            ST_GATE:   if (phase_q == END_GATE)   state_d = ST_DONE;
            ST_DONE:   if (start)                 state_d = ST_PRE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // State register, phase timer and status capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            stat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                phase_q <= '0;
            end else if (state_q != ST_IDLE && state_q != ST_DONE &&
                         state_q != ST_LOAD) begin
                phase_q <= phase_q + 1'b1;
            end
            if (state_q == ST_GATE && phase_q == END_GATE) begin
                stat_q <= stat_s;
            end
        end
    end

    // Outputs per state
    always_comb begin
        pin_o      = '0;
        pin_oe     = '0;
        dut_test_o = 1'b0;
        dut_rst_o  = 1'b0;
        ctl_oe     = 1'b0;
        xi_o       = 1'b0;
        xi_oe      = 1'b0;
        done       = 1'b0;
        pass       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE: begin
                ctl_oe = 1'b1;
            end
            ST_STRAP: begin
                ctl_oe            = 1'b1;
                dut_rst_o         = 1'b1;
                pin_oe[STRAP_IDX] = 1'b1;
                pin_o[STRAP_IDX]  = 1'b1;
                pin_oe[DATA_IDX]  = 1'b1;
                pin_o[DATA_IDX]   = 1'b1;
            end
            ST_LOAD, ST_DRAIN: begin
                ctl_oe           = 1'b1;
                dut_rst_o        = 1'b1;
                pin_oe[REF_IDX]  = 1'b1;
                pin_o[REF_IDX]   = ref_lvl;
                xi_oe            = 1'b1;
                xi_o             = xi_lvl;
                if (state_q == ST_LOAD) begin
                    pin_oe[DATA_IDX] = 1'b1;
                    pin_o[DATA_IDX]  = data_lvl;
                end
            end
            ST_SETTLE, ST_GATE: begin
                ctl_oe    = 1'b1;
                dut_rst_o = 1'b1;
                xi_oe     = 1'b1;
                xi_o      = xi_lvl;
            end
            ST_DONE: begin
                done = 1'b1;
                pass = (stat_q == STATUS_GOOD) &&
                       count_in_window(32'(edge_cnt), EXP_EDGES, TOL);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
    parameter int NUM_PINS  = 64,
    parameter int STRAP_IDX = 59,
    parameter int DATA_IDX  = 63,
    parameter int REF_IDX   = 62
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input logic                pass,
    input logic                bit_valid,
    input logic                bit_ready,
    input logic [NUM_PINS-1:0] pin_o,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                dut_rst_o,
    input logic                ctl_oe,
    input logic                xi_oe
);
    logic [NUM_PINS-1:0] allowed;
    always_comb begin
        allowed            = '0;
        allowed[STRAP_IDX] = 1'b1;
        allowed[DATA_IDX]  = 1'b1;
        allowed[REF_IDX]   = 1'b1;
    end

    assert_pin_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~allowed) == '0);

    assert_strap_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[STRAP_IDX] |-> (pin_o[STRAP_IDX] && pin_oe[DATA_IDX] &&
                               pin_o[DATA_IDX] && dut_rst_o && ctl_oe));

    assert_ready_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ready |-> (pin_oe[DATA_IDX] && !pin_oe[STRAP_IDX] && pin_oe[REF_IDX]));

    assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[DATA_IDX] && !(bit_ready && bit_valid)) |=>
            (!pin_oe[DATA_IDX] || $stable(pin_o[DATA_IDX])));

    assert_ref_context_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[REF_IDX] |-> (xi_oe && dut_rst_o));

    assert_pass_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    assert_done_floats_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pin_oe == '0 && !xi_oe && !ctl_oe));

    assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind pwrup_seq pwrup_seq_chk #(
    .NUM_PINS  (NUM_PINS),
    .STRAP_IDX (STRAP_IDX),
    .DATA_IDX  (DATA_IDX),
    .REF_IDX   (REF_IDX)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .pass      (pass),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .pin_o     (pin_o),
    .pin_oe    (pin_oe),
    .dut_rst_o (dut_rst_o),
    .ctl_oe    (ctl_oe),
    .xi_oe     (xi_oe)
);

// File: tb/pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module pwrup_seq_tb_top;
    localparam int NP     = 64;
    localparam int PRE    = 4;
    localparam int STRAP  = 12;
    localparam int BITC   = 10;
    localparam int RHALF  = 10;
    localparam int XHALF  = 1;
    localparam int POST   = 30;
    localparam int SETTLE = 40;
    localparam int GATE   = 200;
    localparam int EXPE   = 20;
    localparam int PCT    = 5;
    localparam int TOLE   = EXPE * PCT / 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bit_valid = 1'b0, bit_data = 1'b0, bit_last = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic xo_in = 1'b0;
    logic done, pass, bit_ready, dut_test_o, dut_rst_o, ctl_oe, xi_o, xi_oe;
    logic [NP-1:0] pin_o, pin_oe;

    always #5 clk = ~clk;

    pwrup_seq #(
        .PRE_CYC(PRE), .STRAP_CYC(STRAP), .BIT_CYC(BITC), .REF_HALF(RHALF),
        .XI_HALF(XHALF), .POST_CYC(POST), .SETTLE_CYC(SETTLE),
        .GATE_CYC(GATE), .EXP_EDGES(EXPE), .TOL_PCT(PCT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
        .bit_valid(bit_valid), .bit_data(bit_data), .bit_last(bit_last),
        .bit_ready(bit_ready), .pin_o(pin_o), .pin_oe(pin_oe), .pin_in(pin_in),
        .dut_test_o(dut_test_o), .dut_rst_o(dut_rst_o), .ctl_oe(ctl_oe),
        .xi_o(xi_o), .xi_oe(xi_oe), .xo_in(xo_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Bit source and oscillator stimulus
    bit src_q[$];
    bit stall_on = 0;
    int xo_hi = 0, xo_lo = 0, xo_cnt = 0;

    // Reference model state (phases: 0 idle 1 pre 2 strap 3 load 4 drain 5 settle 6 gate 7 done)
    int m_ph = 0, m_cnt = 0, m_tmr = 0, m_edges = 0;
    int r_cnt = 0, x_cnt = 0;
    bit m_busy = 0, m_last = 0, m_lvl = 1, r_lvl = 0, x_lvl = 0;
    bit xs1 = 0, xs2 = 0, xd = 0;
    bit [7:0] st1 = 0, st2 = 0, m_stat = 0;
    bit m_rdy;

    function automatic bit model_ready();
        return (m_ph == 3) && (!m_busy || (m_tmr == BITC - 1 && !m_last));
    endfunction

    function automatic bit model_pass();
        return (m_ph == 7) && (m_stat == 8'hC3) &&
               (m_edges + TOLE >= EXPE) && (m_edges <= EXPE + TOLE);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_busy = 0; m_tmr = 0; m_last = 0; m_lvl = 1;
            r_cnt = 0; r_lvl = 0; x_cnt = 0; x_lvl = 0; xs1 = 0; xs2 = 0; xd = 0;
            m_edges = 0; st1 = 0; st2 = 0; m_stat = 0;
        end else begin
            int ph, nph;
            bit fin, hs, edge_seen;
            ph = m_ph;
            m_rdy = model_ready();
            fin = (ph == 3) && m_busy && m_last && (m_tmr == BITC - 1);
            hs = m_rdy && bit_valid;
            if (ph != 3) begin
                m_busy = 0; m_tmr = 0; m_last = 0; m_lvl = 1;
            end else if (hs) begin
                m_lvl = bit_data; m_last = bit_last; m_busy = 1; m_tmr = 0;
                if (src_q.size() > 0) void'(src_q.pop_front());
            end else if (m_busy) begin
                if (m_tmr == BITC - 1) m_busy = 0; else m_tmr++;
            end
            if (ph == 3 || ph == 4) begin
                if (r_cnt == RHALF - 1) begin r_cnt = 0; r_lvl = ~r_lvl; end else r_cnt++;
            end else begin r_cnt = 0; r_lvl = 0; end
            if (ph >= 3 && ph <= 6) begin
                if (x_cnt == XHALF - 1) begin x_cnt = 0; x_lvl = ~x_lvl; end else x_cnt++;
            end else begin x_cnt = 0; x_lvl = 0; end
            edge_seen = xs2 && !xd;
            if (ph == 5) m_edges = 0;
            else if (ph == 6 && edge_seen) m_edges++;
            xd = xs2; xs2 = xs1; xs1 = xo_in;
            if (ph == 6 && m_cnt == GATE - 1) m_stat = st2;
            st2 = st1; st1 = pin_in[63:56];
            nph = ph;
            case (ph)
                0: if (start) nph = 1;
                1: if (m_cnt == PRE - 1) nph = 2;
                2: if (m_cnt == STRAP - 1) nph = 3;
                3: if (fin) nph = 4;
                4: if (m_cnt == POST - 1) nph = 5;
                5: if (m_cnt == SETTLE - 1) nph = 6;
                6: if (m_cnt == GATE - 1) nph = 7;
                7: if (start) nph = 1;
                default: nph = 0;
            endcase
            if (nph != ph) m_cnt = 0;
            else if (ph != 0 && ph != 7 && ph != 3) m_cnt++;
            m_ph = nph;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [63:0] e_oe;
            e_oe = '0;
            e_oe[59] = (m_ph == 2);
            e_oe[63] = (m_ph == 2 || m_ph == 3);
            e_oe[62] = (m_ph == 3 || m_ph == 4);
            chk(pin_oe == e_oe, "R1 R6 R8 pin_oe", pin_oe, e_oe);
            chk(ctl_oe == (m_ph >= 1 && m_ph <= 6), "R2 ctl_oe", ctl_oe, (m_ph >= 1 && m_ph <= 6));
            chk(dut_test_o == 1'b0, "R2 test line", dut_test_o, 0);
            chk(dut_rst_o == (m_ph >= 2 && m_ph <= 6), "R3 reset line", dut_rst_o, (m_ph >= 2 && m_ph <= 6));
            if (m_ph == 2) chk(pin_o[63] && pin_o[59], "R3 strap levels", {pin_o[63], pin_o[59]}, 2'b11);
            if (m_ph == 3) chk(pin_o[63] == m_lvl, "R4 R5 data level", pin_o[63], m_lvl);
            chk(bit_ready == model_ready(), "R5 bit_ready", bit_ready, model_ready());
            if (m_ph == 3 || m_ph == 4) chk(pin_o[62] == r_lvl, "R7 ref level", pin_o[62], r_lvl);
            chk(xi_oe == (m_ph >= 3 && m_ph <= 6), "R7 xi_oe", xi_oe, (m_ph >= 3 && m_ph <= 6));
            if (xi_oe) chk(xi_o == x_lvl, "R7 xi level", xi_o, x_lvl);
            chk(done == (m_ph == 7), "R11 done", done, (m_ph == 7));
            chk(pass == model_pass(), "R9 pass", pass, model_pass());
        end
    end

    // Stimulus drivers at the falling edge
    always @(negedge clk) begin
        if (src_q.size() > 0 && !(stall_on && (cyc % 23) < 9)) begin
            bit_valid <= 1'b1;
            bit_data  <= src_q[0];
            bit_last  <= (src_q.size() == 1);
        end else begin
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
            bit_last  <= 1'b0;
        end
        if (xo_hi == 0) begin
            xo_in <= 1'b0;
        end else begin
            xo_cnt = (xo_cnt + 1) % (xo_hi + xo_lo);
            xo_in <= (xo_cnt < xo_hi);
        end
    end

    task automatic run_once(input bit [7:0] status, input int hi, input int lo,
                            input bit stall, input int exp_pass, input bit late_flip,
                            input string tag);
        src_q.delete();
        for (int i = 0; i < 9; i++) src_q.push_back(bit'((i * 5 + 3) % 3 == 0));
        stall_on = stall;
        xo_hi = hi; xo_lo = lo; xo_cnt = 0;
        pin_in = '0;
        pin_in[63:56] = status;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!(m_ph == 6 && m_cnt == GATE - 1)) @(negedge clk);
        if (late_flip) pin_in[63:56] = 8'h00;
        while (!done) @(negedge clk);
        @(negedge clk);
        if (exp_pass >= 0)
            chk(pass == exp_pass[0], tag, pass, exp_pass[0]);
        chk(pin_oe == '0 && !xi_oe && !ctl_oe, "R11 all released", pin_oe, 0);
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R11 done held", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 0 && pass == 0 && pin_oe == '0 && !ctl_oe && !xi_oe,
            "R1 reset state", {done, pass, ctl_oe, xi_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(pin_oe == '0 && !ctl_oe, "R1 idle state", pin_oe, 0);
        run_once(8'hC3, 5, 5, 0, 1,  0, "R9 good run passes");
        run_once(8'hC3, 5, 5, 1, 1,  0, "R5 stalled source still passes");
        run_once(8'hC2, 5, 5, 0, 0,  0, "R9 wrong status fails");
        run_once(8'hC3, 3, 3, 0, 0,  0, "R9 fast oscillator fails");
        run_once(8'hC3, 0, 0, 0, 0,  0, "R9 stuck oscillator fails");
        run_once(8'hC3, 5, 6, 0, -1, 0, "R9 window edge");
        run_once(8'hC3, 5, 5, 0, 1,  1, "R10 late status change unseen");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule